// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block keeps one processor's small write-back cache coherent with its peers on a shared snooping bus. Each line sits in one of three states: Invalid, Shared (clean, possibly also held elsewhere) or Exclusive (this cache owns it and it is dirty). Processor loads and stores arrive on a request/ready handshake. Accesses that need the bus raise a request to an external arbiter. Once granted, the block places a read, read-exclusive, invalidate or writeback transaction on the bus. Memory, or a cache that supplies the line, answers a fill with a separate strobe.

At the same time the block watches every transaction that other caches place on the bus. A read that hits a line owned here is answered from this cache. The block drives the line data, tells memory to stay silent and downgrades the line to Shared. Memory captures the same data as the writeback. A read-exclusive or invalidate that hits a valid line kills it. Snoops take the state array ahead of the processor, so a processor access in a snoop cycle waits.

The cache is direct-mapped. The low address bits select the line and the remaining bits form the tag. Every access that misses, and every store to a Shared line, goes through the bus. The bus serializes all writes to a line, and a store only finishes after its bus grant.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req` and `snp_supply` are low, and the first access to any line misses.
- R2: A load miss raises `bus_req` and, on grant, issues one read (command 00) at the load address. The line then holds the fill data in Shared state, and a later load of that address returns it with no bus activity.
- R3: A store miss issues one read-exclusive (command 01) at the store address and fills the line in Exclusive state. The store data then overwrites the line, and a later load returns it with no bus activity.
- R4: A store that hits an Exclusive line completes with `bus_req` never raised.
- R5: A store that hits a Shared line raises `bus_req` and waits for grant, however long that takes. It then issues an invalidate (command 10) at the store address and completes only after that, leaving the line Exclusive.
- R6: A snooped read (command 00) that hits an Exclusive line drives the line onto `snp_data` with `snp_supply` and `snp_abort` high in the same cycle. It leaves the line Shared, so the next local store needs an invalidate.
- R7: A snooped read-exclusive (01) hitting an Exclusive line supplies it like R6. A snooped read-exclusive or invalidate (10) hitting a valid line leaves it Invalid, so the next local load misses.
- R8: A snoop that misses, a snooped read of a Shared line, and a snooped writeback (11) do not assert `snp_supply` or `snp_abort` and leave the line unchanged.
- R9: A miss whose victim is Exclusive first issues a writeback (command 11) carrying the victim's address and data, then the read or read-exclusive. A Shared victim is dropped with no bus transaction.
- R10: In a cycle with `snp_valid` high, `cpu_ready` stays low.
- R11: Bus commands use a 2-bit code: 00 read, 01 read-exclusive, 10 invalidate, 11 writeback. `mst_valid` is high only in a cycle where `bus_gnt` is high.
- R12: The line index is address bits [1:0] and the tag is the rest. A hit needs a tag match and a non-Invalid state, so a different tag on the same index misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DW | Load data, valid with cpu_ready |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted to this cache |
| mst_valid | output | 1 | This cache drives a transaction this cycle |
| mst_cmd | output | 2 | Command of the driven transaction |
| mst_addr | output | AW | Address of the driven transaction |
| mst_data | output | DW | Writeback data |
| fill_valid | input | 1 | Fill data for the outstanding read is present |
| fill_data | input | DW | Fill data |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | AW | Snooped address |
| snp_supply | output | 1 | This cache drives the snooped line |
| snp_abort | output | 1 | Memory must not respond |
| snp_data | output | DW | Supplied line data |

## Verification
Every line index is driven through the same state walk: load miss, load hit, store to Shared with a delayed grant, store to Exclusive, snooped read, snooped read-exclusive, snooped invalidate, snooped writeback, then evictions. The load miss and load hit show that fills land and that hits stay off the bus. Stores to Shared and Exclusive lines show whether the state bit really decides if an invalidate is needed. A store right after a snooped read shows the downgrade, because it has to invalidate again. Evicting a dirty line and a clean line shows the ordered writeback against the silent drop. A snoop issued while a load is pending shows that the snoop takes priority.

// File: rtl/snc_pkg.sv
package snc_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'b00,
    LN_SHD = 2'b01,
    LN_EXC = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    BC_RD  = 2'b00,
    BC_RDX = 2'b01,
    BC_INV = 2'b10,
    BC_WB  = 2'b11
  } bus_cmd_e;

  typedef enum logic [2:0] {
    C_IDLE,
    C_WBREQ,
    C_MISSREQ,
    C_FILL,
    C_INVREQ
  } ctl_st_e;
endpackage

// File: rtl/snc_rst_sync.sv
module snc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/snc_line_store.sv
module snc_line_store #(
  parameter int LINES = 4,
  parameter int TAGW  = 6,
  parameter int DW    = 16,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         c_we_st,
  input  logic                         c_we_tag,
  input  logic                         c_we_data,
  input  logic [IDXW-1:0]              c_idx,
  input  logic [1:0]                   c_st,
  input  logic [TAGW-1:0]              c_tag,
  input  logic [DW-1:0]                c_data,
  input  logic                         s_we,
  input  logic [IDXW-1:0]              s_idx,
  input  logic [1:0]                   s_st,
  output logic [LINES-1:0][1:0]        st_o,
  output logic [LINES-1:0][TAGW-1:0]   tag_o,
  output logic [LINES-1:0][DW-1:0]     data_o
);
  import snc_pkg::*;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel_s, sel_c;
    assign sel_s = s_we && (s_idx == IDXW'(g));
    assign sel_c = c_idx == IDXW'(g);

    // snoop updates take priority over processor-side updates
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                st_o[g] <= LN_INV;
      else if (sel_s)            st_o[g] <= s_st;
      else if (c_we_st && sel_c) st_o[g] <= c_st;
    end

    always_ff @(posedge clk) begin
      if (c_we_tag && sel_c)  tag_o[g]  <= c_tag;
      if (c_we_data && sel_c) data_o[g] <= c_data;
    end
  end
endmodule

// File: rtl/snc_snoop_match.sv
module snc_snoop_match #(
  parameter int LINES = 4,
  parameter int AW    = 8,
  parameter int DW    = 16,
  localparam int IDXW = $clog2(LINES),
  localparam int TAGW = AW - IDXW
) (
  input  logic                       snp_valid,
  input  logic [1:0]                 snp_cmd,
  input  logic [AW-1:0]              snp_addr,
  input  logic [LINES-1:0][1:0]      st_i,
  input  logic [LINES-1:0][TAGW-1:0] tag_i,
  input  logic [LINES-1:0][DW-1:0]   data_i,
  output logic                       supply,
  output logic                       abort,
  output logic [DW-1:0]              data_o,
  output logic                       upd_we,
  output logic [IDXW-1:0]            upd_idx,
  output logic [1:0]                 upd_st
);
  import snc_pkg::*;

  logic [1:0] st;
  logic       hit;

  assign upd_idx = snp_addr[IDXW-1:0];
  assign st      = st_i[upd_idx];
  assign hit     = (st != LN_INV) && (tag_i[upd_idx] == snp_addr[AW-1:IDXW]);
  assign data_o  = data_i[upd_idx];
  assign abort   = supply;

  always_comb begin
    supply = 1'b0;
    upd_we = 1'b0;
    upd_st = LN_INV;
    if (snp_valid && hit) begin
      case (snp_cmd)
        BC_RD: if (st == LN_EXC) begin
          supply = 1'b1;
          upd_we = 1'b1;
          upd_st = LN_SHD;
        end
        BC_RDX: begin
          supply = (st == LN_EXC);
          upd_we = 1'b1;
        end
        BC_INV:  upd_we = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int LINES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mst_valid,
  output logic [1:0]    mst_cmd,
  output logic [AW-1:0] mst_addr,
  output logic [DW-1:0] mst_data,
  input  logic          fill_valid,
  input  logic [DW-1:0] fill_data,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_supply,
  output logic          snp_abort,
  output logic [DW-1:0] snp_data
);
  import snc_pkg::*;

  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = AW - IDXW;

  logic                       srst_n;
  logic [LINES-1:0][1:0]      st_v;
  logic [LINES-1:0][TAGW-1:0] tag_v;
  logic [LINES-1:0][DW-1:0]   data_v;

  logic            s_we;
  logic [IDXW-1:0] s_idx;
  logic [1:0]      s_st;

  logic            wr_st, wr_tag, wr_data;
  logic [1:0]      n_st;
  logic [DW-1:0]   n_data;

  logic [IDXW-1:0] c_idx;
  logic [TAGW-1:0] c_tag;
  logic [1:0]      c_st;
  logic            c_hit, c_dirty;

  ctl_st_e state_q, state_d;

  snc_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  snc_line_store #(.LINES(LINES), .TAGW(TAGW), .DW(DW)) u_store (
    .clk(clk), .rst_n(srst_n),
    .c_we_st(wr_st), .c_we_tag(wr_tag), .c_we_data(wr_data),
    .c_idx(c_idx), .c_st(n_st), .c_tag(c_tag), .c_data(n_data),
    .s_we(s_we), .s_idx(s_idx), .s_st(s_st),
    .st_o(st_v), .tag_o(tag_v), .data_o(data_v)
  );

  snc_snoop_match #(.LINES(LINES), .AW(AW), .DW(DW)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .st_i(st_v), .tag_i(tag_v), .data_i(data_v),
    .supply(snp_supply), .abort(snp_abort), .data_o(snp_data),
    .upd_we(s_we), .upd_idx(s_idx), .upd_st(s_st)
  );

  assign c_idx     = cpu_addr[IDXW-1:0];
  assign c_tag     = cpu_addr[AW-1:IDXW];
  assign c_st      = st_v[c_idx];
  assign c_hit     = (c_st != LN_INV) && (tag_v[c_idx] == c_tag);
  assign c_dirty   = c_st == LN_EXC;
  assign cpu_rdata = data_v[c_idx];

  // next-state and output decode
  always_comb begin
    state_d   = state_q;
    cpu_ready = 1'b0;
    bus_req   = 1'b0;
    mst_valid = 1'b0;
    mst_cmd   = BC_RD;
    mst_addr  = cpu_addr;
    mst_data  = data_v[c_idx];
    wr_st     = 1'b0;
    wr_tag    = 1'b0;
    wr_data   = 1'b0;
    n_st      = LN_INV;
    n_data    = cpu_wdata;
    case (state_q)
      C_IDLE: if (cpu_req && !snp_valid) begin
        if (c_hit) begin
          if (!cpu_we) cpu_ready = 1'b1;
          else if (c_dirty) begin
            cpu_ready = 1'b1;
            wr_data   = 1'b1;
          end else state_d = C_INVREQ;
        end else if (c_dirty) state_d = C_WBREQ;
        else                  state_d = C_MISSREQ;
      end
      C_WBREQ: begin
        bus_req  = 1'b1;
        mst_cmd  = BC_WB;
        mst_addr = {tag_v[c_idx], c_idx};
        if (bus_gnt) begin
          if (c_dirty && !c_hit) begin
            mst_valid = 1'b1;
            wr_st     = 1'b1;
            state_d   = C_MISSREQ;
          end else state_d = C_IDLE;
        end
      end
      C_MISSREQ: begin
        bus_req = 1'b1;
        mst_cmd = cpu_we ? BC_RDX : BC_RD;
        if (bus_gnt) begin
          mst_valid = 1'b1;
          state_d   = C_FILL;
        end
      end
      C_FILL: begin
        bus_req = 1'b1;
        if (fill_valid) begin
          wr_st   = 1'b1;
          wr_tag  = 1'b1;
          wr_data = 1'b1;
          n_st    = cpu_we ? LN_EXC : LN_SHD;
          n_data  = fill_data;
          state_d = C_IDLE;
        end
      end
      C_INVREQ: begin
        bus_req = 1'b1;
        mst_cmd = BC_INV;
        if (bus_gnt) begin
          if (c_hit && c_st == LN_SHD) begin
            mst_valid = 1'b1;
            wr_st     = 1'b1;
            n_st      = LN_EXC;
          end
          state_d = C_IDLE;
        end
      end
      default: state_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= C_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/snc_checker.sv
module snc_checker #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int LINES = 4,
  localparam int IDXW = $clog2(LINES),
  localparam int TAGW = AW - IDXW
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cpu_req,
  input logic                       cpu_we,
  input logic                       cpu_ready,
  input logic                       bus_req,
  input logic                       bus_gnt,
  input logic                       mst_valid,
  input logic                       snp_valid,
  input logic [1:0]                 snp_cmd,
  input logic [AW-1:0]              snp_addr,
  input logic                       snp_supply,
  input logic                       snp_abort,
  input logic [LINES-1:0][1:0]      line_st,
  input logic [LINES-1:0][TAGW-1:0] line_tag
);
  logic [IDXW-1:0] sidx;
  logic [TAGW-1:0] stag;
  assign sidx = snp_addr[IDXW-1:0];
  assign stag = snp_addr[AW-1:IDXW];

  a_r11_issue_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    mst_valid |-> bus_gnt);

  a_r10_snoop_stalls_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_ready);

  a_r4_local_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |-> (cpu_req && !bus_req));

  a_r6_supply_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_abort && snp_valid && !snp_cmd[1]));

  a_r6_downgrade: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_supply && snp_cmd == 2'b00) |=> line_st[$past(sidx)] == 2'b01);

  a_r7_snoop_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && (snp_cmd == 2'b01 || snp_cmd == 2'b10))
      |=> (line_st[$past(sidx)] == 2'b00) || (line_tag[$past(sidx)] != $past(stag)));
endmodule

bind snoop_cache_ctrl snc_checker #(.AW(AW), .DW(DW), .LINES(LINES)) u_chk (
  .clk(clk), .rst_n(srst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mst_valid(mst_valid), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_addr(snp_addr), .snp_supply(snp_supply), .snp_abort(snp_abort),
  .line_st(st_v), .line_tag(tag_v)
);

// File: tb/sim_snoop_cache_ctrl.sv
module sim_snoop_cache_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we, cpu_ready;
  logic [7:0]  cpu_addr;
  logic [15:0] cpu_wdata, cpu_rdata;
  logic        bus_req, bus_gnt, mst_valid;
  logic [1:0]  mst_cmd;
  logic [7:0]  mst_addr;
  logic [15:0] mst_data;
  logic        fill_valid;
  logic [15:0] fill_data;
  logic        snp_valid;
  logic [1:0]  snp_cmd;
  logic [7:0]  snp_addr;
  logic        snp_supply, snp_abort;
  logic [15:0] snp_data;

  int checks = 0;
  int fails  = 0;
  bit done_all = 0;

  logic [15:0] mem [0:255];
  logic [1:0]  lg_cmd  [0:7];
  logic [7:0]  lg_addr [0:7];
  logic [15:0] lg_data [0:7];
  int          lg_n;
  bit          req_seen;

  snoop_cache_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mst_valid(mst_valid), .mst_cmd(mst_cmd), .mst_addr(mst_addr),
    .mst_data(mst_data), .fill_valid(fill_valid), .fill_data(fill_data),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_supply(snp_supply), .snp_abort(snp_abort), .snp_data(snp_data)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] initv(int a);
    return 16'(a * 7 + 5);
  endfunction

  function automatic logic [7:0] A(int t, int i);
    return 8'(t * 4 + i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one processor access, with a bus/memory model answering its transactions
  task automatic run_op(input logic we, input logic [7:0] addr, input logic [15:0] wd,
                        input int gdel, output logic [15:0] rd);
    int gcnt = 0;
    bit prev_req = 0;
    bit fillp = 0;
    bit done = 0;
    logic [15:0] fd = '0;
    lg_n = 0;
    req_seen = 0;
    rd = '0;
    for (int it = 0; it < 60 && !done; it++) begin
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
      bus_gnt = prev_req && (gcnt >= gdel);
      fill_valid = fillp; fill_data = fd;
      #2;
      if (fill_valid) fillp = 0;
      if (mst_valid) begin
        if (lg_n < 8) begin
          lg_cmd[lg_n] = mst_cmd; lg_addr[lg_n] = mst_addr; lg_data[lg_n] = mst_data;
        end
        lg_n++;
        if (mst_cmd == 2'b11) mem[mst_addr] = mst_data;
        else if (mst_cmd != 2'b10) begin
          fillp = 1; fd = mem[mst_addr];
        end
      end
      if (bus_req) begin
        req_seen = 1; gcnt++;
      end else gcnt = 0;
      prev_req = bus_req;
      if (cpu_ready) begin
        rd = cpu_rdata; done = 1;
      end
    end
    @(negedge clk);
    cpu_req = 1'b0; bus_gnt = 1'b0; fill_valid = 1'b0;
    if (!done) chk("op_completes", 32'(addr), 32'hFFFF_FFFF);
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [7:0] addr, input logic exp_sup,
                       input logic [15:0] exp_data, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = addr;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = addr;
    #2;
    chk({req, " supply"}, 32'(snp_supply), 32'(exp_sup));
    chk({req, " abort"}, 32'(snp_abort), 32'(exp_sup));
    chk("R10 cpu stalled by snoop", 32'(cpu_ready), 32'd0);
    if (exp_sup) chk({req, " data"}, 32'(snp_data), 32'(exp_data));
    if (snp_supply && cmd == 2'b00) mem[addr] = snp_data;
    @(negedge clk);
    snp_valid = 1'b0; cpu_req = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done_all) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<50000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] rd;
    for (int k = 0; k < 256; k++) mem[k] = initv(k);
    rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    bus_gnt = 0; fill_valid = 0; fill_data = '0;
    snp_valid = 0; snp_cmd = '0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk("R1 bus_req after reset", 32'(bus_req), 32'd0);
    chk("R1 snp_supply after reset", 32'(snp_supply), 32'd0);

    for (int i = 0; i < 4; i++) begin
      // R1/R2 load miss fills Shared
      run_op(1'b0, A(1, i), '0, 0, rd);
      chk("R1 first access misses", 32'(lg_n), 32'd1);
      chk("R11 read command 00", 32'(lg_cmd[0]), 32'd0);
      chk("R2 read address", 32'(lg_addr[0]), 32'(A(1, i)));
      chk("R2 fill data", 32'(rd), 32'(initv(A(1, i))));
      run_op(1'b0, A(1, i), '0, 0, rd);
      chk("R2 hit no bus", 32'(req_seen), 32'd0);
      chk("R2 hit data", 32'(rd), 32'(initv(A(1, i))));
      // R5 store to Shared with delayed grant
      run_op(1'b1, A(1, i), 16'hA000 + 16'(i), 3, rd);
      chk("R5 one transaction", 32'(lg_n), 32'd1);
      chk("R5 invalidate command 10", 32'(lg_cmd[0]), 32'd2);
      chk("R5 invalidate address", 32'(lg_addr[0]), 32'(A(1, i)));
      // R4 store to Exclusive
      run_op(1'b1, A(1, i), 16'hB000 + 16'(i), 0, rd);
      chk("R4 no bus request", 32'(req_seen), 32'd0);
      run_op(1'b0, A(1, i), '0, 0, rd);
      chk("R4 store data", 32'(rd), 32'(16'hB000 + 16'(i)));
      // R6 snooped read of Exclusive
      snoop(2'b00, A(1, i), 1'b1, 16'hB000 + 16'(i), "R6 snoop read");
      run_op(1'b1, A(1, i), 16'hC000 + 16'(i), 0, rd);
      chk("R6 downgraded line needs invalidate", 32'(lg_cmd[0]), 32'd2);
      // R7 snooped read-exclusive of Exclusive
      snoop(2'b01, A(1, i), 1'b1, 16'hC000 + 16'(i), "R7 snoop rdx");
      run_op(1'b0, A(1, i), '0, 0, rd);
      chk("R7 rdx leaves Invalid", 32'(lg_n), 32'd1);
      chk("R7 refill from memory", 32'(rd), 32'(16'hB000 + 16'(i)));
      // R7 snooped invalidate of Shared
      snoop(2'b10, A(1, i), 1'b0, '0, "R7 snoop inv");
      run_op(1'b0, A(1, i), '0, 0, rd);
      chk("R7 inv leaves Invalid", 32'(lg_cmd[0]), 32'd0);
      // R8 snoops with no effect
      snoop(2'b00, A(1, i), 1'b0, '0, "R8 read of Shared");
      snoop(2'b00, A(2, i), 1'b0, '0, "R8 snoop miss");
      snoop(2'b11, A(1, i), 1'b0, '0, "R8 snooped writeback");
      run_op(1'b0, A(1, i), '0, 0, rd);
      chk("R8 line still held", 32'(req_seen), 32'd0);
      // R3 store miss with silent Shared eviction (R9)
      run_op(1'b1, A(2, i), 16'hD000 + 16'(i), 0, rd);
      chk("R9 Shared victim silent", 32'(lg_n), 32'd1);
      chk("R3 read-exclusive command 01", 32'(lg_cmd[0]), 32'd1);
      chk("R3 read-exclusive address", 32'(lg_addr[0]), 32'(A(2, i)));
      run_op(1'b0, A(2, i), '0, 0, rd);
      chk("R3 store data held", 32'(rd), 32'(16'hD000 + 16'(i)));
      chk("R3 hit no bus", 32'(req_seen), 32'd0);
      // R9 dirty eviction, R12 tag compare
      run_op(1'b0, A(3, i), '0, 0, rd);
      chk("R12 other tag misses", 32'(lg_n), 32'd2);
      chk("R9 writeback command 11", 32'(lg_cmd[0]), 32'd3);
      chk("R9 writeback address", 32'(lg_addr[0]), 32'(A(2, i)));
      chk("R9 writeback data", 32'(lg_data[0]), 32'(16'hD000 + 16'(i)));
      chk("R9 then read", 32'(lg_cmd[1]), 32'd0);
      chk("R9 new line data", 32'(rd), 32'(initv(A(3, i))));
      run_op(1'b0, A(2, i), '0, 0, rd);
      chk("R12 miss back to old tag", 32'(lg_n), 32'd1);
      chk("R9 written-back data read", 32'(rd), 32'(16'hD000 + 16'(i)));
    end

    done_all = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule